// File: doc/BRIEF.md
# Flash Completion Wait Engine

This block runs after a flash command sequencer has sent an operation to a flash device and has to find out when the device is finished. One start pulse carries a policy code (read-type completion, program/erase completion, or device reset) and a flag that says whether a ready/busy pin is wired. The engine always waits out a write-to-busy guard interval first. It then waits for completion in one of three ways: by watching the synchronized ready/busy pin, by polling the device status register through a byte read port, or by waiting a blind fixed delay. Each way has its own timeout.

When it finishes, the engine pulses `done_o` once. It also presents a status byte and a timeout flag, which stay valid until the next completion. All delays are counted in clock cycles, derived from a clock-frequency parameter and from time parameters in microseconds and nanoseconds. A simulation can therefore pass short timeouts.

Top module: `flash_wait_engine`

## Requirements
- R1: After reset, `done_o`, `timeout_o` and `rd_req_o` are low and `status_o` is 8'h00.
- R2: After an accepted start, no status transaction is requested and no completion is reported until at least TWB_CYC = ceil(TWB_NS x CLK_HZ / 1e9) clock cycles have elapsed (13 cycles at 125 MHz and 100 ns).
- R3: With `policy_i` = 0 (read) and `pin_avail_i` = 1, the engine completes once the pin reads high (ready) after two synchronizer flops. In that case `status_o` = 8'h40 and `timeout_o` = 0, and no status traffic takes place.
- R4: On the pin path, if the pin stays low for RDY_TMO_US microseconds after the guard, the engine completes with `timeout_o` = 1 and `status_o` = 8'h00.
- R5: With policy 0 and no pin, the engine waits the guard plus `cfg_delay_us_i` microseconds and completes with `status_o` = 8'h40 and `timeout_o` = 0. It issues no status transactions.
- R6: A `cfg_delay_us_i` of zero is replaced by DEF_DELAY_US microseconds.
- R7: With `policy_i` = 1 (program/erase), the engine first issues exactly one status-command transaction (`rd_cmd_o` = 1). It then waits for ready, using the pin if available and otherwise repeated status-byte reads (ready = bit 6), and finally performs one further status-byte read.
- R8: After program/erase, `status_o` is the final byte unchanged, including fail bit 0, and `timeout_o` is the inverse of its bit 6.
- R9: With `policy_i` = 2 (reset) and a pin, the engine takes the pin path of R3/R4 with no status traffic.
- R10: With policy 2 and no pin, the engine waits the chip delay, issues one status command and polls status reads until bit 6 is set. It gives up after RST_TMO_US microseconds with `timeout_o` = 1. `status_o` is the last byte read.
- R11: When the ready indication and the expiry of the timeout are seen in the same decision cycle, ready wins.
- R12: A start pulse while an operation is in progress is ignored.
- R13: `done_o` is a one-cycle pulse. `status_o` and `timeout_o` hold their values until the next completion.
- R14: `rd_req_o` stays high and `rd_cmd_o` stays unchanged until `rd_ack_i` completes the transaction. Each cycle with both high is one transaction, and `rd_data_i` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| policy_i | input | 2 | 0 read, 1 program/erase, 2 reset (3 treated as read) |
| pin_avail_i | input | 1 | Ready/busy pin is wired |
| rb_pin_i | input | 1 | Ready/busy pin, high = ready, asynchronous |
| cfg_delay_us_i | input | DLY_W | Blind chip delay in microseconds, 0 = default |
| rd_req_o | output | 1 | Status transaction request |
| rd_cmd_o | output | 1 | 1 = send status command, 0 = read status byte |
| rd_ack_i | input | 1 | Transaction completes this cycle |
| rd_data_i | input | 8 | Status byte, valid with the acknowledge of a read |
| done_o | output | 1 | Completion pulse |
| status_o | output | 8 | Final status byte |
| timeout_o | output | 1 | Completion reached without ready |

## Verification
Two decisions can land in one cycle: the ready indication arriving and the timeout limit expiring. On the pin path, the bench sweeps the cycle at which the pin rises across an eight-point window around the nominal expiry. It does the same on the status-polling reset path for the cycle in which the device first returns bit 6. For every run, the bench judges the result against the cycle in which ready became visible to the decision. A timeout is allowed only if ready could not yet be seen, and a success only if it could. Across the sweep, both outcomes must occur.

// File: rtl/wfe_pkg.sv
package wfe_pkg;
    typedef enum logic [1:0] {
        POL_READ  = 2'd0,
        POL_PROG  = 2'd1,
        POL_RESET = 2'd2
    } wfe_pol_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_CDELAY,
        ST_SCMD,
        ST_PPIN,
        ST_PSTAT,
        ST_FINAL
    } wfe_state_e;

    localparam int unsigned RDY_BIT = 6;
    localparam logic [7:0]  STAT_READY = 8'h40;
endpackage

// File: rtl/wfe_sync.sv
module wfe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wfe_timer.sv
module wfe_timer #(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned CYC_W      = 6,
    parameter int unsigned US_W       = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic [US_W-1:0]  us_o
);
    localparam int unsigned PRE_W = $clog2(CYC_PER_US) + 1;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [PRE_W-1:0] pre;
        logic [US_W-1:0]  us;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr_i) begin
            t_d = '0;
        end else begin
            if (t_q.cyc != '1) t_d.cyc = t_q.cyc + 1'b1;
            if (t_q.pre == PRE_W'(CYC_PER_US - 1)) begin
                t_d.pre = '0;
                if (t_q.us != '1) t_d.us = t_q.us + 1'b1;
            end else begin
                t_d.pre = t_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign cyc_o = t_q.cyc;
    assign us_o  = t_q.us;

    // time base for every delay and timeout never runs backwards (R4, R10)
    assert_us_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> us_o >= $past(us_o));
endmodule

// File: rtl/wfe_route.sv
module wfe_route
    import wfe_pkg::*;
#(
    parameter int unsigned US_W       = 20,
    parameter int unsigned RDY_TMO_US = 400_000,
    parameter int unsigned RST_TMO_US = 250_000
) (
    input  wfe_pol_e          pol_i,
    input  logic              pin_i,
    output wfe_state_e        first_o,
    output logic [US_W-1:0]   tmo_lim_o
);
    always_comb begin
        if (pol_i == POL_PROG)  first_o = ST_SCMD;
        else if (pin_i)         first_o = ST_PPIN;
        else                    first_o = ST_CDELAY;

        if (pol_i == POL_RESET && !pin_i) tmo_lim_o = US_W'(RST_TMO_US);
        else                              tmo_lim_o = US_W'(RDY_TMO_US);
    end
endmodule

// File: rtl/flash_wait_engine.sv
module flash_wait_engine
    import wfe_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 125_000_000,
    parameter int unsigned TWB_NS       = 100,
    parameter int unsigned RDY_TMO_US   = 400_000,
    parameter int unsigned RST_TMO_US   = 250_000,
    parameter int unsigned DEF_DELAY_US = 20,
    parameter int unsigned DLY_W        = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [1:0]       policy_i,
    input  logic             pin_avail_i,
    input  logic             rb_pin_i,
    input  logic [DLY_W-1:0] cfg_delay_us_i,
    output logic             rd_req_o,
    output logic             rd_cmd_o,
    input  logic             rd_ack_i,
    input  logic [7:0]       rd_data_i,
    output logic             done_o,
    output logic [7:0]       status_o,
    output logic             timeout_o
);
    localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned TWB_RAW    = (CYC_PER_US * TWB_NS + 999) / 1000;
    localparam int unsigned TWB_CYC    = (TWB_RAW > 0) ? TWB_RAW : 1;
    localparam int unsigned CYC_W      = $clog2(TWB_CYC + 1) + 1;
    localparam int unsigned DLY_MAX    = (1 << DLY_W) - 1;
    localparam int unsigned TMO_MAX    = (RDY_TMO_US > RST_TMO_US) ? RDY_TMO_US : RST_TMO_US;
    localparam int unsigned US_MAX     = (TMO_MAX > DLY_MAX) ? TMO_MAX : DLY_MAX;
    localparam int unsigned US_W       = $clog2(US_MAX + 1) + 1;

    typedef struct packed {
        wfe_state_e       st;
        wfe_pol_e         pol;
        logic             pin;
        logic [DLY_W-1:0] dly;
        logic [7:0]       stat;
        logic             tmo;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic             rb_s;
    logic             tmr_clr;
    logic [CYC_W-1:0] tmr_cyc;
    logic [US_W-1:0]  tmr_us;
    wfe_state_e       first_st;
    logic [US_W-1:0]  tmo_lim;
    logic             is_prog;
    logic             timed_out;

    wfe_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rb_pin_i),
        .q_o    (rb_s)
    );

    wfe_timer #(.CYC_PER_US(CYC_PER_US), .CYC_W(CYC_W), .US_W(US_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .cyc_o  (tmr_cyc),
        .us_o   (tmr_us)
    );

    wfe_route #(.US_W(US_W), .RDY_TMO_US(RDY_TMO_US), .RST_TMO_US(RST_TMO_US)) u_route (
        .pol_i     (r_q.pol),
        .pin_i     (r_q.pin),
        .first_o   (first_st),
        .tmo_lim_o (tmo_lim)
    );

    assign is_prog   = (r_q.pol == POL_PROG);
    assign timed_out = (tmr_us >= tmo_lim);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_clr  = 1'b0;
        rd_req_o = 1'b0;
        rd_cmd_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_GUARD;
                    r_d.pol = (policy_i == 2'd3) ? POL_READ : wfe_pol_e'(policy_i);
                    r_d.pin = pin_avail_i;
                    r_d.dly = (cfg_delay_us_i == '0) ? DLY_W'(DEF_DELAY_US) : cfg_delay_us_i;
                    tmr_clr = 1'b1;
                end
            end
            ST_GUARD: begin
                if (tmr_cyc >= CYC_W'(TWB_CYC - 1)) begin
                    r_d.st  = first_st;
                    tmr_clr = 1'b1;
                end
            end
            ST_CDELAY: begin
                if (tmr_us >= US_W'(r_q.dly)) begin
                    tmr_clr = 1'b1;
                    if (r_q.pol == POL_RESET) begin
                        r_d.st = ST_SCMD;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.stat = STAT_READY;
                        r_d.tmo  = 1'b0;
                    end
                end
            end
            ST_SCMD: begin
                rd_req_o = 1'b1;
                rd_cmd_o = 1'b1;
                if (rd_ack_i) begin
                    tmr_clr = 1'b1;
                    r_d.st  = r_q.pin ? ST_PPIN : ST_PSTAT;
                end
            end
            ST_PPIN: begin
                if (rb_s || timed_out) begin
                    if (is_prog) begin
                        r_d.st = ST_FINAL;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.stat = rb_s ? STAT_READY : 8'h00;
                        r_d.tmo  = !rb_s;
                    end
                end
            end
            ST_PSTAT: begin
                rd_req_o = 1'b1;
                if (rd_ack_i && (rd_data_i[RDY_BIT] || timed_out)) begin
                    if (is_prog) begin
                        r_d.st = ST_FINAL;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.stat = rd_data_i;
                        r_d.tmo  = !rd_data_i[RDY_BIT];
                    end
                end
            end
            ST_FINAL: begin
                rd_req_o = 1'b1;
                if (rd_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.stat = rd_data_i;
                    r_d.tmo  = !rd_data_i[RDY_BIT];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.pol <= POL_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign status_o  = r_q.stat;
    assign timeout_o = r_q.tmo;

    // cycles elapsed since the last accepted start, used by the guard checks
    logic [CYC_W-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          age_q <= '0;
        else if (r_q.st == ST_IDLE && start_i) age_q <= '0;
        else if (age_q != '1)                 age_q <= age_q + 1'b1;
    end

    assert_guard_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |-> age_q >= CYC_W'(TWB_CYC));

    assert_guard_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> age_q >= CYC_W'(TWB_CYC));

    assert_no_traffic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != ST_IDLE && r_q.pol == POL_READ && !r_q.pin) |-> !rd_req_o);

    assert_final_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && r_q.pol == POL_PROG) |-> (timeout_o == !status_o[RDY_BIT]));

    assert_busy_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != ST_IDLE && start_i) |=> $stable(r_q.pol) && $stable(r_q.pin));

    assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_req_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_o && !rd_ack_i) |=> rd_req_o && $stable(rd_cmd_o));
endmodule

// File: tb/tb_flash_wait_engine.sv
module tb_flash_wait_engine;
    localparam int CPU     = 125;
    localparam int TWB     = 13;
    localparam int RDY_LIM = 40;
    localparam int RST_LIM = 25;
    localparam int DEF_DLY = 20;
    localparam int NEVER   = 32'h3fff_ffff;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  policy = 2'd0;
    logic        pin_avail = 1'b0;
    logic        rb_pin = 1'b0;
    logic [15:0] cfg_dly = 16'd0;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        rd_req, rd_cmd, done, timeout;
    logic [7:0]  status;

    int cyc = 0, total = 0, bad = 0;
    int pin_rel = NEVER, dev_rdy_read = NEVER, dev_rdy_cyc = NEVER;
    logic dev_fail = 1'b0;
    int n_cmd = 0, n_read = 0;
    int s_edge, d_edge, lat;
    logic [7:0] got_stat;
    logic got_tmo, hung, pulse_ok;

    flash_wait_engine #(
        .CLK_HZ(125_000_000), .TWB_NS(100), .RDY_TMO_US(RDY_LIM),
        .RST_TMO_US(RST_LIM), .DEF_DELAY_US(DEF_DLY), .DLY_W(16)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .policy_i(policy),
        .pin_avail_i(pin_avail), .rb_pin_i(rb_pin), .cfg_delay_us_i(cfg_dly),
        .rd_req_o(rd_req), .rd_cmd_o(rd_cmd), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
        .done_o(done), .status_o(status), .timeout_o(timeout)
    );

    initial forever #4 clk = ~clk;
    initial forever @(posedge clk) cyc++;
    initial forever @(negedge clk) rb_pin = (cyc >= pin_rel);

    // flash device model answering status transactions
    initial forever @(negedge clk) begin
        if (rd_req) begin
            rd_ack = 1'b1;
            if (rd_cmd) begin
                n_cmd++;
                rd_data = 8'h00;
            end else begin
                n_read++;
                if (n_read >= dev_rdy_read || cyc >= dev_rdy_cyc)
                    rd_data = {1'b0, 1'b1, 5'b0, dev_fail};
                else
                    rd_data = {7'b0, dev_fail};
            end
        end else begin
            rd_ack  = 1'b0;
            rd_data = 8'h00;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // rel_pin: pin first sampled high at start edge + rel_pin (-1 = already high)
    // rel_rdy: status ready first sampled at start edge + rel_rdy
    task automatic run(input logic [1:0] pol, input logic pin, input int dly,
                       input int rel_pin, input int rdy_read, input int rel_rdy,
                       input logic fail, input bit poke);
        pin_rel      = (rel_pin < 0) ? 0 : NEVER;
        dev_rdy_read = rdy_read;
        dev_rdy_cyc  = NEVER;
        dev_fail     = fail;
        repeat (4) @(negedge clk);
        policy = pol; pin_avail = pin; cfg_dly = 16'(dly);
        start = 1'b1; n_cmd = 0; n_read = 0;
        s_edge = cyc + 1;
        if (rel_pin >= 0 && rel_pin < NEVER) pin_rel = s_edge + rel_pin - 1;
        if (rel_rdy < NEVER) dev_rdy_cyc = s_edge + rel_rdy - 1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (50) @(negedge clk);
            policy = 2'd1; pin_avail = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        hung = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin hung = 1'b0; break; end
            @(negedge clk);
        end
        d_edge = cyc; lat = d_edge - s_edge;
        got_stat = status; got_tmo = timeout;
        check(!hung, "watchdog on completion", 0, 1);
        @(negedge clk);
        pulse_ok = !done && status == got_stat && timeout == got_tmo;
        pin_rel = NEVER; dev_rdy_cyc = NEVER; dev_rdy_read = NEVER;
    endtask

    task automatic t_reset_state;
        check(!done && !timeout && !rd_req, "R1 reset outputs low", {done, timeout, rd_req}, 0);
        check(status == 8'h00, "R1 reset status", status, 0);
    endtask

    task automatic t_read_pin;
        run(2'd0, 1'b1, 3, -1, NEVER, NEVER, 1'b0, 1'b0);
        check(lat >= TWB && lat <= TWB + 4, "R2 guard before pin sample", lat, TWB);
        check(got_stat == 8'h40 && !got_tmo, "R3 pin ready status", got_stat, 8'h40);
        check(n_cmd + n_read == 0, "R3 no status traffic", n_cmd + n_read, 0);
        check(pulse_ok, "R13 one-cycle done and held outputs", pulse_ok, 1);
        run(2'd0, 1'b1, 3, 200, NEVER, NEVER, 1'b0, 1'b0);
        check(lat >= 202 && lat <= 206, "R3 late pin latency", lat, 202);
        check(got_stat == 8'h40 && !got_tmo, "R3 late pin status", got_stat, 8'h40);
    endtask

    task automatic t_pin_timeout;
        run(2'd0, 1'b1, 3, NEVER, NEVER, NEVER, 1'b0, 1'b0);
        check(got_tmo && got_stat == 8'h00, "R4 pin timeout flag", {got_tmo, got_stat}, 256);
        check(lat >= TWB + RDY_LIM * CPU && lat <= TWB + RDY_LIM * CPU + 4,
              "R4 pin timeout latency", lat, TWB + RDY_LIM * CPU);
        check(pulse_ok, "R13 hold after timeout", pulse_ok, 1);
    endtask

    task automatic t_read_blind;
        run(2'd0, 1'b0, 3, NEVER, 1, NEVER, 1'b0, 1'b0);
        check(lat >= TWB + 3 * CPU && lat <= TWB + 3 * CPU + 4, "R5 blind delay latency", lat, TWB + 3 * CPU);
        check(got_stat == 8'h40 && !got_tmo, "R5 blind status", got_stat, 8'h40);
        check(n_cmd + n_read == 0, "R5 no status traffic", n_cmd + n_read, 0);
        run(2'd0, 1'b0, 0, NEVER, 1, NEVER, 1'b0, 1'b0);
        check(lat >= TWB + DEF_DLY * CPU && lat <= TWB + DEF_DLY * CPU + 4,
              "R6 default delay latency", lat, TWB + DEF_DLY * CPU);
    endtask

    task automatic t_prog;
        run(2'd1, 1'b0, 3, NEVER, 5, NEVER, 1'b1, 1'b0);
        check(n_cmd == 1, "R7 one status command", n_cmd, 1);
        check(n_read == 6, "R7 polls plus final read", n_read, 6);
        check(got_stat == 8'h41 && !got_tmo, "R8 fail bit passed through", got_stat, 8'h41);
        run(2'd1, 1'b1, 3, 100, 1, NEVER, 1'b0, 1'b0);
        check(n_cmd == 1 && n_read == 1, "R7 pin wait then final read", n_cmd * 10 + n_read, 11);
        check(lat >= 102 && got_stat == 8'h40 && !got_tmo, "R7 pin program result", got_stat, 8'h40);
        run(2'd1, 1'b0, 3, NEVER, NEVER, NEVER, 1'b1, 1'b0);
        check(got_tmo && got_stat == 8'h01, "R8 busy final byte flags timeout", got_stat, 1);
        check(lat >= TWB + RDY_LIM * CPU && lat <= TWB + RDY_LIM * CPU + 8,
              "R8 program timeout latency", lat, TWB + RDY_LIM * CPU);
    endtask

    task automatic t_reset_ops;
        run(2'd2, 1'b1, 3, 50, 1, NEVER, 1'b0, 1'b0);
        check(n_cmd + n_read == 0 && got_stat == 8'h40 && !got_tmo, "R9 reset on pin path",
              n_cmd + n_read, 0);
        check(lat >= 52 && lat <= 56, "R9 reset pin latency", lat, 52);
        run(2'd2, 1'b0, 1, NEVER, 3, NEVER, 1'b0, 1'b0);
        check(n_cmd == 1 && n_read == 3, "R10 command then polls", n_cmd * 10 + n_read, 13);
        check(got_stat == 8'h40 && !got_tmo && lat >= TWB + CPU, "R10 reset poll result", got_stat, 8'h40);
        run(2'd2, 1'b0, 1, NEVER, NEVER, NEVER, 1'b0, 1'b0);
        check(got_tmo && got_stat == 8'h00, "R10 reset poll timeout", got_tmo, 1);
        check(lat >= TWB + CPU + RST_LIM * CPU && lat <= TWB + CPU + RST_LIM * CPU + 8,
              "R10 reset timeout latency", lat, TWB + CPU + RST_LIM * CPU);
    endtask

    task automatic t_busy_start;
        run(2'd0, 1'b0, 3, NEVER, 1, NEVER, 1'b0, 1'b1);
        check(lat >= TWB + 3 * CPU && lat <= TWB + 3 * CPU + 4, "R12 second start ignored", lat, TWB + 3 * CPU);
        check(n_cmd == 0 && got_stat == 8'h40, "R12 no program traffic", n_cmd, 0);
        repeat (30) @(negedge clk);
        check(!done && !rd_req, "R12 no deferred operation", {done, rd_req}, 0);
    endtask

    task automatic t_race;
        bit seen_ok, seen_to;
        seen_ok = 0; seen_to = 0;
        for (int i = 0; i < 8; i++) begin
            int k;
            run(2'd0, 1'b1, 3, 5006 + 2 * i, NEVER, NEVER, 1'b0, 1'b0);
            k = s_edge + 5006 + 2 * i;
            if (got_tmo) begin
                seen_to = 1;
                check(k >= d_edge - 1, "R11 pin timeout while ready visible", k, d_edge - 1);
            end else begin
                seen_ok = 1;
                check(k <= d_edge - 2 && got_stat == 8'h40, "R11 pin ready before visible", k, d_edge - 2);
            end
        end
        check(seen_ok && seen_to, "R11 pin sweep both outcomes", {seen_ok, seen_to}, 3);
        seen_ok = 0; seen_to = 0;
        for (int i = 0; i < 8; i++) begin
            int k;
            run(2'd2, 1'b0, 1, NEVER, NEVER, 3258 + 2 * i, 1'b0, 1'b0);
            k = s_edge + 3258 + 2 * i;
            if (got_tmo) begin
                seen_to = 1;
                check(k > d_edge, "R11 status timeout while ready read", k, d_edge + 1);
            end else begin
                seen_ok = 1;
                check(k <= d_edge && got_stat == 8'h40, "R11 status ready result", k, d_edge);
            end
        end
        check(seen_ok && seen_to, "R11 status sweep both outcomes", {seen_ok, seen_to}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_read_pin();
        t_pin_timeout();
        t_read_blind();
        t_prog();
        t_reset_ops();
        t_busy_start();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 195000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule